// File: doc/BRIEF.md
# CRC Match Byte Position Tracker

This block watches the bytes of a received frame that follow the start-of-frame delimiter. Two CRC engines run side by side: a 32-bit one and an 8-bit one. A 12-bit byte position counter runs beside them. Each time a byte leaves one of the CRC engines in its "correct" state, the block stores the position of that byte for that engine. At the end of the frame, each stored value is the index of the last byte at which that CRC checked good.

Firmware reads the two stored positions and compares them with the length carried in the frame header. A frame whose CRC ends exactly on its last byte shows a stored position equal to the full byte count, CRC bytes included. The block does not parse headers and does not decide whether a frame is accepted.

A 2-bit header-size input tells the CRCs to skip a few leading bytes. The position counter still counts every byte.

Top module: `crcpos_tracker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the position counter and both stored positions are cleared to zero, and both CRC engines are loaded with their preset values.
- R2: A `sof` pulse clears the position counter and both stored positions, and reloads both CRC preset values. All four output registers read zero in the cycle after it.
- R3: Each accepted byte (`byte_vld` high, `sof` low) advances the position by one. The first byte after `sof` is position 1. CRC bytes are counted as well, so a frame whose CRC is good on its final byte stores its total byte count.
- R4: The 32-bit engine shifts MSB first with polynomial 04C11DB7h and preset FFFFFFFFh. It checks good when its register equals C704DD7Bh after a byte. That happens when the sender appends the inverted remainder, most significant byte first.
- R5: The 8-bit engine shifts MSB first with polynomial 07h and preset 00h. It checks good when its register is 00h after a byte. That happens when the sender appends the remainder itself.
- R6: A stored position is overwritten at every later byte on which its CRC checks good. It keeps the most recent matching index, and the check uses the register value after that byte has been folded in.
- R7: `hdr_sel` sets how many leading bytes are left out of both CRCs: 00 leaves out 0 bytes, 01 leaves out 1, 10 leaves out 2, 11 leaves out 4. Bytes that are left out still advance the position.
- R8: A byte that is left out of the CRCs never updates a stored position. A CRC that never checks good in a frame leaves its stored position at zero.
- R9: The position counter saturates at FFFh. Further bytes keep it there, and a match on such a byte stores FFFh.
- R10: Each stored position appears as a low byte holding bits 7..0 and a high byte holding bits 11..8 in its bits 3..0. Bits 7..4 of each high byte always read zero.
- R11: With neither `sof` nor `byte_vld` high, nothing changes. When `sof` and `byte_vld` are high in the same cycle, the byte is dropped and the position is not advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start-of-frame strobe, one cycle |
| byte_vld | input | 1 | Byte strobe for `byte_data` |
| byte_data | input | 8 | Received byte |
| hdr_sel | input | 2 | Number of leading bytes left out of the CRCs (00:0, 01:1, 10:2, 11:4) |
| c32_pos_lo | output | 8 | 32-bit CRC match position, bits 7..0 |
| c32_pos_hi | output | 8 | 32-bit CRC match position, bits 11..8 in bits 3..0, upper nibble zero |
| c8_pos_lo | output | 8 | 8-bit CRC match position, bits 7..0 |
| c8_pos_hi | output | 8 | 8-bit CRC match position, bits 11..8 in bits 3..0, upper nibble zero |

## Verification
The bench drives frames whose CRC is built over a given number of skipped header bytes. It uses every `hdr_sel` value, short and long frames, a frame with a bad CRC, and a frame whose covered payload is empty.

A frame built with one header size and received with another must show no 32-bit match. A design that applied the skip to the counter, or that ignored the skip, would store a wrong or non-zero position.

The 8-bit engine with a zero preset matches on an initial 00h byte, which the bench uses in several ways:
- It tests last-match-wins: a design that latched the first match would keep 1.
- It tests that skipped bytes are inert: a design that checked skipped bytes would store 1.
- It tests that a byte arriving with `sof` is dropped: a design that counted that byte would store 2.
- With more than 4096 zero bytes, it tests saturation: a wrapping counter would store a small value instead of FFFh.

// File: rtl/crcpos_pkg.sv
`timescale 1ns/1ps
// Package crcpos_pkg
// Shared widths, CRC constants and the header-skip decode for the CRC
// match position tracker. Assumes byte-wide input data.
package crcpos_pkg;

    localparam int POS_W   = 12;
    localparam int BYTE_W  = 8;
    localparam int SKIP_W  = 3;

    localparam int          C32_W       = 32;
    localparam logic [31:0] C32_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] C32_PRESET  = 32'hFFFF_FFFF;
    localparam logic [31:0] C32_RESIDUE = 32'hC704_DD7B;

    localparam int          C8_W        = 8;
    localparam logic [7:0]  C8_POLY     = 8'h07;
    localparam logic [7:0]  C8_PRESET   = 8'h00;
    localparam logic [7:0]  C8_RESIDUE  = 8'h00;

    // Split view of a captured position as two byte-wide registers.
    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } pos_split_t;

    // Number of leading bytes left out of the CRCs for a header setting.
    function automatic logic [SKIP_W-1:0] skip_count(input logic [1:0] sel);
        logic [SKIP_W-1:0] n;
        case (sel)
            2'b00:   n = 3'd0;
            2'b01:   n = 3'd1;
            2'b10:   n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/crcpos_counter.sv
`timescale 1ns/1ps
// Module crcpos_counter
// Saturating byte position counter. Cleared by reset and by sof. Advances
// once per accepted byte (byte_vld without sof). Exposes the current value
// and the value the incoming byte will take. Assumes POS_W >= SKIP_W.
module crcpos_counter #(
    parameter int POS_W  = 12,
    parameter int SKIP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              byte_vld,
    input  logic [SKIP_W-1:0] skip,
    output logic [POS_W-1:0]  pos_q,
    output logic [POS_W-1:0]  pos_nxt,
    output logic              step,
    output logic              covered
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    // Accepted byte, next position with saturation, coverage of this byte.
    always_comb begin
        step    = byte_vld && !sof;
        pos_nxt = (pos_q == POS_MAX) ? POS_MAX : pos_q + POS_W'(1);
        covered = (pos_q >= POS_W'(skip));
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n || sof)
            pos_q <= '0;
        else if (step)
            pos_q <= pos_nxt;
    end

endmodule

// File: rtl/crcpos_lane.sv
`timescale 1ns/1ps
// Module crcpos_lane
// One CRC engine with its own match capture register. Shifts MSB first,
// one byte per accepted covered byte, and compares the updated register
// against RESIDUE. On a match, stores the position of that byte.
// Assumes W >= 2 and that pos_nxt is the index of the byte being accepted.
module crcpos_lane #(
    parameter int          W       = 32,
    parameter logic [W-1:0] POLY    = '0,
    parameter logic [W-1:0] PRESET  = '0,
    parameter logic [W-1:0] RESIDUE = '0,
    parameter int          POS_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             step,
    input  logic             covered,
    input  logic [7:0]       data,
    input  logic [POS_W-1:0] pos_nxt,
    output logic [POS_W-1:0] cap_q
);
    logic [W-1:0] crc_q;
    logic [W-1:0] crc_nxt;
    logic         hit;

    // Byte-wide CRC step: eight serial shifts, data MSB first.
    always_comb begin
        crc_nxt = crc_q;
        for (int b = 7; b >= 0; b--) begin
            if (crc_nxt[W-1] ^ data[b])
                crc_nxt = {crc_nxt[W-2:0], 1'b0} ^ POLY;
            else
                crc_nxt = {crc_nxt[W-2:0], 1'b0};
        end
        hit = step && covered && (crc_nxt == RESIDUE);
    end

    // CRC register: preset on reset and sof, advanced on covered bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || sof)
            crc_q <= PRESET;
        else if (step && covered)
            crc_q <= crc_nxt;
    end

    // Capture register: last byte position at which the CRC checked good.
    always_ff @(posedge clk) begin
        if (!rst_n || sof)
            cap_q <= '0;
        else if (hit)
            cap_q <= pos_nxt;
    end

endmodule

// File: rtl/crcpos_split.sv
`timescale 1ns/1ps
// Module crcpos_split
// Presents a captured position as a low byte and a high byte whose unused
// upper bits read zero. Assumes 9 <= POS_W <= 16.
module crcpos_split #(
    parameter int POS_W = 12
) (
    input  logic [POS_W-1:0]          pos,
    output crcpos_pkg::pos_split_t    view
);
    // Low byte direct, high byte zero-extended.
    always_comb begin
        view.lo = pos[7:0];
        view.hi = 8'(pos[POS_W-1:8]);
    end

endmodule

// File: rtl/crcpos_tracker.sv
`timescale 1ns/1ps
// Module crcpos_tracker
// Top of the CRC match position tracker. A shared saturating byte counter
// feeds two CRC lanes (32-bit and 8-bit). Each lane stores the last byte
// position where its CRC checked good. hdr_sel leaves 0/1/2/4 leading bytes
// out of both CRCs. Assumes hdr_sel is held steady across a frame.
module crcpos_tracker
    import crcpos_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sof,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic [1:0] hdr_sel,
    output logic [7:0] c32_pos_lo,
    output logic [7:0] c32_pos_hi,
    output logic [7:0] c8_pos_lo,
    output logic [7:0] c8_pos_hi
);
    localparam int NLANE = 2;

    logic [SKIP_W-1:0] skip;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  pos_nxt;
    logic              step;
    logic              covered;
    logic [POS_W-1:0]  cap   [NLANE];
    pos_split_t        view  [NLANE];

    // Header setting to skipped byte count.
    always_comb skip = skip_count(hdr_sel);

    crcpos_counter #(.POS_W(POS_W), .SKIP_W(SKIP_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (sof),
        .byte_vld (byte_vld),
        .skip     (skip),
        .pos_q    (pos_q),
        .pos_nxt  (pos_nxt),
        .step     (step),
        .covered  (covered)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        if (g == 0) begin : g_c32
            crcpos_lane #(
                .W(C32_W), .POLY(C32_POLY), .PRESET(C32_PRESET),
                .RESIDUE(C32_RESIDUE), .POS_W(POS_W)
            ) u_lane (
                .clk(clk), .rst_n(rst_n), .sof(sof), .step(step),
                .covered(covered), .data(byte_data), .pos_nxt(pos_nxt),
                .cap_q(cap[g])
            );
        end else begin : g_c8
            crcpos_lane #(
                .W(C8_W), .POLY(C8_POLY), .PRESET(C8_PRESET),
                .RESIDUE(C8_RESIDUE), .POS_W(POS_W)
            ) u_lane (
                .clk(clk), .rst_n(rst_n), .sof(sof), .step(step),
                .covered(covered), .data(byte_data), .pos_nxt(pos_nxt),
                .cap_q(cap[g])
            );
        end
        crcpos_split #(.POS_W(POS_W)) u_split (
            .pos  (cap[g]),
            .view (view[g])
        );
    end

    // Output register views.
    always_comb begin
        c32_pos_lo = view[0].lo;
        c32_pos_hi = view[0].hi;
        c8_pos_lo  = view[1].lo;
        c8_pos_hi  = view[1].hi;
    end

endmodule

// File: rtl/crcpos_checker.sv
`timescale 1ns/1ps
// Module crcpos_checker
// Assertions for crcpos_tracker, attached by bind below.
module crcpos_checker #(
    parameter int POS_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof,
    input logic             byte_vld,
    input logic [POS_W-1:0] pos_q,
    input logic [7:0]       c32_pos_lo,
    input logic [7:0]       c32_pos_hi,
    input logic [7:0]       c8_pos_lo,
    input logic [7:0]       c8_pos_hi
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [11:0] c32_pos;
    logic [11:0] c8_pos;
    always_comb begin
        c32_pos = {c32_pos_hi[3:0], c32_pos_lo};
        c8_pos  = {c8_pos_hi[3:0],  c8_pos_lo};
    end

    a_r2_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (pos_q == '0 && c32_pos == '0 && c8_pos == '0));

    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !sof && pos_q != POS_MAX) |=> pos_q == $past(pos_q) + POS_W'(1));

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !sof && pos_q == POS_MAX) |=> pos_q == POS_MAX);

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && !byte_vld) |=> ($stable(pos_q) && $stable(c32_pos) && $stable(c8_pos)));

    a_r8_cap_not_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        (POS_W'(c32_pos) <= pos_q) && (POS_W'(c8_pos) <= pos_q));

    a_r10_hi_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (c32_pos_hi[7:4] == 4'h0) && (c8_pos_hi[7:4] == 4'h0));

endmodule

bind crcpos_tracker crcpos_checker #(.POS_W(crcpos_pkg::POS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof        (sof),
    .byte_vld   (byte_vld),
    .pos_q      (pos_q),
    .c32_pos_lo (c32_pos_lo),
    .c32_pos_hi (c32_pos_hi),
    .c8_pos_lo  (c8_pos_lo),
    .c8_pos_hi  (c8_pos_hi)
);

// File: tb/sim_crcpos_tracker.sv
`timescale 1ns/1ps
// Bench for crcpos_tracker: a vector table of frames, then directed cases.
module sim_crcpos_tracker;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sof;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic [1:0] hdr_sel;
    logic [7:0] c32_pos_lo, c32_pos_hi, c8_pos_lo, c8_pos_hi;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    crcpos_tracker u0 (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
        .byte_data(byte_data), .hdr_sel(hdr_sel),
        .c32_pos_lo(c32_pos_lo), .c32_pos_hi(c32_pos_hi),
        .c8_pos_lo(c8_pos_lo), .c8_pos_hi(c8_pos_hi)
    );

    // Vector fields: [37:36] drive hdr, [35:34] build hdr, [33] kind
    // (0: 32-bit CRC appended, 1: 8-bit CRC appended), [32] corrupt,
    // [31:24] seed, [23:12] bytes before CRC, [11:0] expected position.
    localparam int NVEC = 8;
    localparam logic [37:0] VEC [0:NVEC-1] = '{
        {2'd0, 2'd0, 1'b0, 1'b0, 8'h11, 12'd20,  12'd24},
        {2'd1, 2'd1, 1'b0, 1'b0, 8'h27, 12'd9,   12'd13},
        {2'd2, 2'd2, 1'b1, 1'b0, 8'h35, 12'd15,  12'd16},
        {2'd3, 2'd3, 1'b0, 1'b0, 8'h4B, 12'd300, 12'd304},
        {2'd3, 2'd3, 1'b1, 1'b0, 8'h59, 12'd40,  12'd41},
        {2'd0, 2'd0, 1'b0, 1'b1, 8'h63, 12'd30,  12'd0},
        {2'd2, 2'd2, 1'b0, 1'b0, 8'h71, 12'd2,   12'd6},
        {2'd0, 2'd2, 1'b0, 1'b0, 8'h85, 12'd12,  12'd0}
    };

    function automatic int skip_of(input logic [1:0] s);
        return (s == 2'd3) ? 4 : int'(s);
    endfunction

    function automatic logic [31:0] ref_c32(input logic [31:0] c, input logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    function automatic logic [7:0] ref_c8(input logic [7:0] c, input logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = c[7] ^ d[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic check_pos(input string tag, input logic [7:0] lo,
                             input logic [7:0] hi, input logic [11:0] exp);
        tests++;
        if (hi[7:4] != 4'h0 || {hi[3:0], lo} != exp) begin
            fails++;
            $display("FAIL %s: got hi=%02h lo=%02h expected %03h", tag, hi, lo, exp);
        end
    endtask

    task automatic pulse_sof(input logic [1:0] h);
        @(negedge clk);
        hdr_sel  = h;
        sof      = 1'b1;
        byte_vld = 1'b0;
        @(negedge clk);
        sof      = 1'b0;
    endtask

    // Drives one byte (inputs change at the falling edge, so the byte is
    // taken at the next rising edge).
    task automatic put_byte(input logic [7:0] d);
        byte_vld  = 1'b1;
        byte_data = d;
        @(negedge clk);
        byte_vld  = 1'b0;
    endtask

    task automatic run_vec(input int idx);
        logic [37:0] v;
        logic [7:0]  fr [0:319];
        logic [31:0] c32;
        logic [7:0]  c8;
        int          n;
        int          bsk;
        int          dsk;
        logic [11:0] mpos, mcap32, mcap8;
        logic [31:0] m32;
        logic [7:0]  m8;
        v   = VEC[idx];
        bsk = skip_of(v[35:34]);
        dsk = skip_of(v[37:36]);
        c32 = 32'hFFFFFFFF;
        c8  = 8'h00;
        n   = int'(v[23:12]);
        for (int k = 0; k < n; k++) begin
            fr[k] = 8'(k * int'(v[31:24]) + 60);
            if (k >= bsk) begin
                c32 = ref_c32(c32, fr[k]);
                c8  = ref_c8(c8, fr[k]);
            end
        end
        if (!v[33]) begin
            c32 = ~c32;
            fr[n] = c32[31:24]; fr[n+1] = c32[23:16];
            fr[n+2] = c32[15:8]; fr[n+3] = c32[7:0];
            n = n + 4;
        end else begin
            fr[n] = c8;
            n = n + 1;
        end
        if (v[32]) fr[n-1] = fr[n-1] ^ 8'h01;
        pulse_sof(v[37:36]);
        mpos = 0; mcap32 = 0; mcap8 = 0; m32 = 32'hFFFFFFFF; m8 = 8'h00;
        for (int k = 0; k < n; k++) begin
            put_byte(fr[k]);
            if (mpos != 12'hFFF) mpos = mpos + 12'd1;
            if (int'(mpos) > dsk) begin
                m32 = ref_c32(m32, fr[k]);
                m8  = ref_c8(m8, fr[k]);
                if (m32 == 32'hC704DD7B) mcap32 = mpos;
                if (m8 == 8'h00)         mcap8  = mpos;
            end
        end
        // R3 R4 R5 R7: table expectation for the CRC appended to the frame.
        if (!v[33])
            check_pos($sformatf("R4 R3 R7 vec%0d c32", idx), c32_pos_lo, c32_pos_hi, v[11:0]);
        else
            check_pos($sformatf("R5 R3 R7 vec%0d c8", idx), c8_pos_lo, c8_pos_hi, v[11:0]);
        // R6 R8 R10: both lanes against the running model.
        check_pos($sformatf("R6 R8 vec%0d c32 model", idx), c32_pos_lo, c32_pos_hi, mcap32);
        check_pos($sformatf("R6 R8 vec%0d c8 model", idx), c8_pos_lo, c8_pos_hi, mcap8);
    endtask

    initial begin
        rst_n = 1'b0; sof = 1'b0; byte_vld = 1'b0; byte_data = 8'h00; hdr_sel = 2'd0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check_pos("R1 reset c32", c32_pos_lo, c32_pos_hi, 12'h000);
        check_pos("R1 reset c8",  c8_pos_lo,  c8_pos_hi,  12'h000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R2: sof after a frame with stored positions clears them.
        pulse_sof(2'd0);
        check_pos("R2 sof clears c32", c32_pos_lo, c32_pos_hi, 12'h000);
        check_pos("R2 sof clears c8",  c8_pos_lo,  c8_pos_hi,  12'h000);

        // R5 R6: 00h matches the 8-bit CRC at byte 1, a later good CRC wins.
        put_byte(8'h00);
        check_pos("R5 first zero byte c8", c8_pos_lo, c8_pos_hi, 12'h001);
        put_byte(8'hAB);
        put_byte(8'hCD);
        put_byte(ref_c8(ref_c8(8'h00, 8'hAB), 8'hCD));
        check_pos("R6 last match wins c8", c8_pos_lo, c8_pos_hi, 12'h004);

        // R11: idle cycles change nothing.
        repeat (5) @(negedge clk);
        check_pos("R11 idle hold c8", c8_pos_lo, c8_pos_hi, 12'h004);

        // R8 R7: a skipped 00h byte must not capture.
        pulse_sof(2'd1);
        put_byte(8'h00);
        check_pos("R8 skipped byte c8", c8_pos_lo, c8_pos_hi, 12'h000);
        // R7: the next byte is covered and is position 2.
        put_byte(8'h00);
        check_pos("R7 first covered byte c8", c8_pos_lo, c8_pos_hi, 12'h002);

        // R11: byte arriving together with sof is dropped.
        @(negedge clk);
        hdr_sel = 2'd0; sof = 1'b1; byte_vld = 1'b1; byte_data = 8'h12;
        @(negedge clk);
        sof = 1'b0; byte_vld = 1'b0;
        put_byte(8'h00);
        check_pos("R11 sof drops byte c8", c8_pos_lo, c8_pos_hi, 12'h001);

        // R9 R10: 4100 zero bytes saturate at FFFh.
        pulse_sof(2'd0);
        for (int k = 0; k < 4100; k++) put_byte(8'h00);
        check_pos("R9 R10 saturate c8", c8_pos_lo, c8_pos_hi, 12'hFFF);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule